// File: doc/BRIEF.md
# Dynamic memory bus width adapter

This block sits between a processor-side request port and a memory port whose data width may differ from one access to the next. One processor load or store of 1, 2 or 4 bytes (or up to the full processor width) becomes the sequence of memory cycles that the selected memory width needs. For each of those cycles the block produces the memory address and byte enables, steers write bytes onto the memory lanes, and gathers read bytes back into one processor word.

Processor byte addresses need not be aligned. An access that runs past the end of a memory word is split into as many memory cycles as it covers. A mode input chooses little- or big-endian byte order between the processor word and memory addresses. The memory acknowledge input paces each memory cycle, so wait states are decided outside the block. The memory width comes with each request, so memories of different widths can share one address space.

Top module: `mem_width_adapter`

## Requirements
- R1: While reset is low, and in the first cycle after it, `mem_stb`, `cpu_ack` and `mem_be` are all zero.
- R2: Size code and memory-width code both mean 2^code bytes (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes). A code above log2 of the processor byte count is treated as the full processor width, so code 3 means 4 bytes on a 32-bit port.
- R3: An access of N bytes at byte address A on a memory of M bytes takes exactly ceil(((A mod M) + N) / M) memory cycles. For example, a word on byte memory takes 4 cycles, a halfword on byte memory takes 2, and an aligned byte or halfword on 16- or 32-bit memory takes 1.
- R4: Memory cycle c (counting from 0) puts out the address (A rounded down to a multiple of M) + c*M.
- R5: Memory lane j carries bits [8j+7:8j] and holds byte address mem_addr + j. Byte enable j is set exactly when j < M and that byte address lies in [A, A+N). Every memory cycle enables at least one lane.
- R6: With `cpu_big_endian` = 0, the byte at address A+k corresponds to processor data bits [8k+7:8k].
- R7: With `cpu_big_endian` = 1, the byte at address A+k corresponds to processor data bits [8(N-1-k)+7:8(N-1-k)].
- R8: On a load, `cpu_rdata` holds the assembled bytes while `cpu_ack` is high. Processor bytes at positions N and above read as zero.
- R9: On a store, every memory cycle has `mem_we` = 1, each enabled lane carries its processor byte, and lanes that are not enabled carry zero.
- R10: A memory cycle ends only on a clock edge with `mem_ack` high. Until then, `mem_stb`, `mem_addr`, `mem_be`, `mem_we` and `mem_wdata` stay unchanged, so any number of wait states may be inserted.
- R11: `cpu_ack` is high for exactly one clock, in the cycle right after the edge that acknowledged the last memory cycle, and `mem_stb` is low in that cycle.
- R12: The block samples all request inputs only when it accepts a request. Changes to them while an access is in progress have no effect on that access.
- R13: Back-to-back accesses may each use a different memory width, and each follows the width given with its own request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_stb | input | 1 | Request valid; held until `cpu_ack` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Processor byte address |
| cpu_size | input | CODE_W | Access size code (R2) |
| cpu_mem_width | input | CODE_W | Memory width code for this access (R2) |
| cpu_big_endian | input | 1 | Byte order select (R6, R7) |
| cpu_wdata | input | DW | Store data, right-justified |
| cpu_ack | output | 1 | One-clock completion pulse |
| cpu_rdata | output | DW | Load data, valid with `cpu_ack` |
| mem_stb | output | 1 | Memory cycle active |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Memory byte address, aligned to the memory width |
| mem_be | output | DW/8 | Lane byte enables |
| mem_wdata | output | DW | Memory write data per lane |
| mem_rdata | input | DW | Memory read data per lane |
| mem_ack | input | 1 | Memory cycle complete |

## Verification
The bench builds the block with DW = 32, AW = 32 and CODE_W = 2. With these values all three memory widths (8, 16 and 32 bits) and the clamping of code 3 to the full width can be exercised. Misaligned splits of two and three cycles are also reachable, in both byte orders and under zero to several wait states. A 32-bit port is enough to cover every lane-mapping case, because each case depends only on the offset within the memory word and on the access length.

// File: rtl/mwa_pkg.sv
// Package for the memory width adapter: sequencer state and the code clamp.
// Assumes size and width codes are no wider than 8 bits.
package mwa_pkg;

    typedef enum logic [1:0] {
        MWA_IDLE = 2'd0,
        MWA_RUN  = 2'd1,
        MWA_DONE = 2'd2
    } mwa_state_e;

    // Limit a log2 byte-count code to the largest one the port supports.
    function automatic logic [7:0] mwa_clamp(input logic [7:0] code, input logic [7:0] lim);
        return (code > lim) ? lim : code;
    endfunction

endpackage

// File: rtl/mwa_seq.sv
// Memory cycle sequencer: idle -> run (one step per memory ack) -> done (one clock).
// Assumes ncyc is at least 1 and stays stable for the whole access.
module mwa_seq
    import mwa_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mem_ack,
    input  logic [CNT_W-1:0] ncyc,
    output mwa_state_e       state,
    output logic [CNT_W-1:0] cyc,
    output logic             last
);

    // Flags the final memory cycle of the access.
    assign last = (cyc == ncyc - CNT_W'(1));

    // State and cycle index update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= MWA_IDLE;
            cyc   <= '0;
        end else begin
            case (state)
                MWA_IDLE: begin
                    if (start) begin
                        state <= MWA_RUN;
                        cyc   <= '0;
                    end
                end
                MWA_RUN: begin
                    if (mem_ack) begin
                        if (last) state <= MWA_DONE;
                        else      cyc   <= cyc + CNT_W'(1);
                    end
                end
                MWA_DONE: state <= MWA_IDLE;
                default:  state <= MWA_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mwa_lane_map.sv
// Lane map: for the current memory cycle, decides which memory lanes belong to
// the access and which processor byte each of them maps to.
// Assumes wlog <= log2(NB) and nbytes <= NB; IW holds values up to 4*NB-1.
module mwa_lane_map #(
    parameter int NB    = 4,
    parameter int IW    = 4,
    parameter int CNT_W = 3,
    parameter int SRC_W = 2
) (
    input  logic [CNT_W-1:0]          cyc,
    input  logic [IW-1:0]             wlog,
    input  logic [IW-1:0]             mbytes,
    input  logic [IW-1:0]             off,
    input  logic [IW-1:0]             nbytes,
    input  logic                      big,
    output logic [NB-1:0]             lane_en,
    output logic [NB-1:0][SRC_W-1:0]  lane_src
);

    for (genvar j = 0; j < NB; j++) begin : g_lane
        logic [IW-1:0] pos;
        logic [IW-1:0] k;

        // Byte position of this lane relative to the first aligned memory word.
        assign pos = (IW'(cyc) << wlog) + IW'(j);
        // Byte index within the access.
        assign k   = pos - off;
        // Lane belongs to the access when it is inside the memory word and the span.
        assign lane_en[j]  = (IW'(j) < mbytes) && (pos >= off) && (k < nbytes);
        // Processor byte position, mirrored for big-endian order.
        assign lane_src[j] = big ? SRC_W'(nbytes - IW'(1) - k) : SRC_W'(k);
    end

endmodule

// File: rtl/mwa_rd_pack.sv
// Read accumulator: clears at request accept and stores each acknowledged
// lane into its processor byte position.
// Assumes enabled lanes never share a processor byte position.
module mwa_rd_pack #(
    parameter int NB    = 4,
    parameter int SRC_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      capture,
    input  logic [NB-1:0]             lane_en,
    input  logic [NB-1:0][SRC_W-1:0]  lane_src,
    input  logic [NB*8-1:0]           mem_rdata,
    output logic [NB*8-1:0]           acc
);

    // Byte gather into the processor word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clear) begin
            acc <= '0;
        end else if (capture) begin
            for (int j = 0; j < NB; j++) begin
                if (lane_en[j]) acc[{lane_src[j], 3'b000} +: 8] <= mem_rdata[j*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/mem_width_adapter.sv
// Dynamic memory bus width adapter: splits one processor access into memory
// cycles of a per-request width, handling misalignment and byte order.
// Assumes DW is a power of two >= 16 and memory data sits on the low lanes.
module mem_width_adapter
    import mwa_pkg::*;
#(
    parameter int DW     = 32,
    parameter int AW     = 32,
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_stb,
    input  logic              cpu_we,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [CODE_W-1:0] cpu_size,
    input  logic [CODE_W-1:0] cpu_mem_width,
    input  logic              cpu_big_endian,
    input  logic [DW-1:0]     cpu_wdata,
    output logic              cpu_ack,
    output logic [DW-1:0]     cpu_rdata,
    output logic              mem_stb,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW/8-1:0]   mem_be,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_ack
);

    localparam int NB     = DW / 8;
    localparam int LOG_NB = $clog2(NB);
    localparam int IW     = LOG_NB + 2;
    localparam int CNT_W  = LOG_NB + 1;
    localparam int SRC_W  = LOG_NB;

    mwa_state_e             state;
    logic [CNT_W-1:0]       cyc;
    logic [CNT_W-1:0]       ncyc;
    logic                   last;
    logic                   start;
    logic                   run;

    logic                   r_we;
    logic                   r_big;
    logic [AW-1:0]          r_addr;
    logic [IW-1:0]          r_slog;
    logic [IW-1:0]          r_wlog;
    logic [DW-1:0]          r_wdata;

    logic [IW-1:0]          mbytes;
    logic [IW-1:0]          nbytes;
    logic [IW-1:0]          off;
    logic [IW-1:0]          span;
    logic [AW-1:0]          base;

    logic [NB-1:0]            lane_en;
    logic [NB-1:0][SRC_W-1:0] lane_src;

    // Request acceptance and cycle activity.
    assign start = (state == MWA_IDLE) && cpu_stb;
    assign run   = (state == MWA_RUN);

    // Request capture; inputs are ignored outside acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_we    <= 1'b0;
            r_big   <= 1'b0;
            r_addr  <= '0;
            r_slog  <= '0;
            r_wlog  <= '0;
            r_wdata <= '0;
        end else if (start) begin
            r_we    <= cpu_we;
            r_big   <= cpu_big_endian;
            r_addr  <= cpu_addr;
            r_slog  <= IW'(mwa_clamp(8'(cpu_size), 8'(LOG_NB)));
            r_wlog  <= IW'(mwa_clamp(8'(cpu_mem_width), 8'(LOG_NB)));
            r_wdata <= cpu_wdata;
        end
    end

    // Access geometry derived from the captured request.
    assign mbytes = IW'(1) << r_wlog;
    assign nbytes = IW'(1) << r_slog;
    assign off    = {{(IW - LOG_NB){1'b0}}, r_addr[LOG_NB-1:0]} & (mbytes - IW'(1));
    assign span   = off + nbytes;
    assign ncyc   = CNT_W'((span + mbytes - IW'(1)) >> r_wlog);
    assign base   = r_addr & ~(AW'(mbytes) - AW'(1));

    mwa_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mem_ack (mem_ack),
        .ncyc    (ncyc),
        .state   (state),
        .cyc     (cyc),
        .last    (last)
    );

    mwa_lane_map #(
        .NB    (NB),
        .IW    (IW),
        .CNT_W (CNT_W),
        .SRC_W (SRC_W)
    ) u_lane_map (
        .cyc      (cyc),
        .wlog     (r_wlog),
        .mbytes   (mbytes),
        .off      (off),
        .nbytes   (nbytes),
        .big      (r_big),
        .lane_en  (lane_en),
        .lane_src (lane_src)
    );

    mwa_rd_pack #(
        .NB    (NB),
        .SRC_W (SRC_W)
    ) u_rd_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .capture   (run && mem_ack),
        .lane_en   (lane_en),
        .lane_src  (lane_src),
        .mem_rdata (mem_rdata),
        .acc       (cpu_rdata)
    );

    // Memory side strobes, address and enables.
    assign mem_stb  = run;
    assign mem_we   = run && r_we;
    assign mem_addr = base + (AW'(cyc) << r_wlog);
    assign mem_be   = run ? lane_en : '0;
    assign cpu_ack  = (state == MWA_DONE);

    // Write byte steering per lane.
    for (genvar j = 0; j < NB; j++) begin : g_wlane
        assign mem_wdata[j*8 +: 8] = (run && r_we && lane_en[j])
                                     ? r_wdata[{lane_src[j], 3'b000} +: 8] : 8'h00;
    end

endmodule

// File: rtl/mwa_checker.sv
// Protocol checker for the memory width adapter, bound to every instance.
// Assumes the synchronous active-low reset of the adapter.
module mwa_checker #(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_stb,
    input logic            mem_we,
    input logic            mem_ack,
    input logic [AW-1:0]   mem_addr,
    input logic [DW/8-1:0] mem_be,
    input logic [DW-1:0]   mem_wdata,
    input logic            cpu_ack
);

    logic [DW-1:0] be_mask;
    logic          rst_seen;

    // Bit mask of the enabled lanes.
    always_comb begin
        for (int j = 0; j < DW/8; j++) be_mask[j*8 +: 8] = {8{mem_be[j]}};
    end

    // Remembers that reset was low at the previous edge.
    always_ff @(posedge clk) rst_seen <= !rst_n;

    // R1: outputs quiet right after reset.
    always_ff @(posedge clk) begin
        if (rst_seen) begin
            p_idle_after_reset_r1: assert (!mem_stb && !cpu_ack && mem_be == '0);
        end
    end

    p_be_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_stb |-> (mem_be != '0));

    p_be_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_stb |-> (mem_be == '0));

    p_wdata_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_stb && mem_we) |-> ((mem_wdata & ~be_mask) == '0));

    p_hold_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_stb && !mem_ack) |=> (mem_stb && $stable(mem_addr) && $stable(mem_be)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    p_ack_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_stb && mem_ack) |=> (mem_stb || cpu_ack));

    p_ack_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

    p_ack_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> !mem_stb);

endmodule

bind mem_width_adapter mwa_checker #(
    .DW (DW),
    .AW (AW)
) u_mwa_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_stb   (mem_stb),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .cpu_ack   (cpu_ack)
);

// File: tb/mem_width_adapter_tb.sv
// Directed bench for the memory width adapter with a byte-array memory model.
module mem_width_adapter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 32;
    localparam int NB = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_stb = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [1:0]    cpu_size = '0;
    logic [1:0]    cpu_mem_width = '0;
    logic          cpu_big_endian = 1'b0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ack;
    logic [DW-1:0] cpu_rdata;
    logic          mem_stb;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [NB-1:0] mem_be;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_ack = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit finished = 1'b0;

    logic [7:0]    mem_img [256];
    logic [AW-1:0] log_addr [16];
    logic [NB-1:0] log_be [16];
    logic [DW-1:0] log_wd [16];
    int log_n = 0;
    int stb_cycles = 0;
    int last_ack_cyc = 0;
    int ws = 0;
    int wcnt = 0;
    int cur_mb = 4;

    mem_width_adapter #(.DW(DW), .AW(AW), .CODE_W(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_stb(cpu_stb), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_mem_width(cpu_mem_width),
        .cpu_big_endian(cpu_big_endian), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack),
        .cpu_rdata(cpu_rdata), .mem_stb(mem_stb), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cycles <= cycles + 1;

    // Memory model: acknowledges after ws wait cycles, logs each cycle, applies writes.
    always @(negedge clk) begin
        if (mem_stb) begin
            stb_cycles = stb_cycles + 1;
            if (wcnt == ws) begin
                mem_ack = 1'b1;
                wcnt = 0;
                for (int j = 0; j < NB; j++) begin
                    if (j < cur_mb) mem_rdata[j*8 +: 8] = mem_img[(mem_addr + j) & 255];
                    else            mem_rdata[j*8 +: 8] = 8'hEE;
                    if (mem_we && mem_be[j]) mem_img[(mem_addr + j) & 255] = mem_wdata[j*8 +: 8];
                end
                if (log_n < 16) begin
                    log_addr[log_n] = mem_addr;
                    log_be[log_n]   = mem_be;
                    log_wd[log_n]   = mem_wdata;
                end
                log_n = log_n + 1;
                last_ack_cyc = cycles;
            end else begin
                mem_ack = 1'b0;
                wcnt = wcnt + 1;
            end
        end else begin
            mem_ack = 1'b0;
            wcnt = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // One processor access with full checking of the memory cycles and result.
    task automatic run_access(input string name, input bit we, input logic [AW-1:0] addr,
                              input int size_code, input int width_code, input bit big,
                              input logic [DW-1:0] wdata, input int wait_n, input bit scramble);
        int n  = 1 << ((size_code > 2) ? 2 : size_code);
        int mb = 1 << ((width_code > 2) ? 2 : width_code);
        int a0 = int'(addr);
        int off = a0 % mb;
        int base = a0 - off;
        int exp_ncyc = (off + n + mb - 1) / mb;
        int guard = 0;
        int ack_cyc;
        int bad = 0;
        logic [DW-1:0] rd;
        logic [DW-1:0] exp_rd = '0;
        logic [7:0] exp_img [256];
        string ord = big ? "R7" : "R6";

        exp_img = mem_img;
        for (int k = 0; k < n; k++) begin
            int b = big ? (n - 1 - k) : k;
            exp_rd[b*8 +: 8] = mem_img[(a0 + k) & 255];
            if (we) exp_img[(a0 + k) & 255] = wdata[b*8 +: 8];
        end

        @(negedge clk);
        ws = wait_n;
        cur_mb = mb;
        log_n = 0;
        stb_cycles = 0;
        cpu_we = we;
        cpu_addr = addr;
        cpu_size = 2'(size_code);
        cpu_mem_width = 2'(width_code);
        cpu_big_endian = big;
        cpu_wdata = wdata;
        cpu_stb = 1'b1;
        do begin
            @(negedge clk);
            guard++;
            if (scramble) begin
                cpu_addr = ~addr;
                cpu_wdata = ~wdata;
                cpu_size = 2'd0;
                cpu_mem_width = 2'd2;
                cpu_big_endian = ~big;
                cpu_we = ~we;
            end
        end while (!cpu_ack && guard < 200);
        ack_cyc = cycles;
        rd = cpu_rdata;
        cpu_stb = 1'b0;

        chk(guard < 200, {name, " R11 ack arrives"}, 64'(guard), 64'(0));
        chk(log_n == exp_ncyc, {name, " R3 memory cycle count"}, 64'(log_n), 64'(exp_ncyc));
        for (int c = 0; c < exp_ncyc && c < log_n && c < 16; c++) begin
            logic [NB-1:0] ebe = '0;
            logic [DW-1:0] ewd = '0;
            int ma = base + c * mb;
            for (int j = 0; j < NB; j++) begin
                if (j < mb && ma + j >= a0 && ma + j < a0 + n) begin
                    int k = ma + j - a0;
                    int b = big ? (n - 1 - k) : k;
                    ebe[j] = 1'b1;
                    ewd[j*8 +: 8] = wdata[b*8 +: 8];
                end
            end
            chk(log_addr[c] == AW'(ma), {name, " R4 memory address"}, 64'(log_addr[c]), 64'(ma));
            chk(log_be[c] == ebe, {name, " R5 byte enables"}, 64'(log_be[c]), 64'(ebe));
            if (we) chk(log_wd[c] == ewd, {name, " R9 ", ord, " write lanes"}, 64'(log_wd[c]), 64'(ewd));
        end
        chk(stb_cycles == exp_ncyc * (wait_n + 1), {name, " R10 strobe cycles with waits"},
            64'(stb_cycles), 64'(exp_ncyc * (wait_n + 1)));
        chk(ack_cyc == last_ack_cyc + 1, {name, " R11 ack timing"}, 64'(ack_cyc), 64'(last_ack_cyc + 1));
        if (!we) begin
            chk(rd == exp_rd, {name, " R8 ", ord, " read data"}, 64'(rd), 64'(exp_rd));
        end else begin
            for (int i = 0; i < 256; i++) if (mem_img[i] != exp_img[i]) bad++;
            chk(bad == 0, {name, " R9 ", ord, " memory image"}, 64'(bad), 64'(0));
        end
        @(negedge clk);
        chk(!cpu_ack, {name, " R11 ack one clock"}, 64'(cpu_ack), 64'(0));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!mem_stb && !cpu_ack && mem_be == '0, "R1 quiet during reset",
            64'({mem_stb, cpu_ack, mem_be}), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_stb && !cpu_ack, "R1 idle after reset", 64'({mem_stb, cpu_ack}), 64'(0));
    endtask

    // R3, R6, R8: word and halfword on byte memory.
    task automatic t_narrow_memory();
        run_access("byte-mem word LE", 1'b0, 32'h10, 2, 0, 1'b0, '0, 0, 1'b0);
        run_access("byte-mem half BE", 1'b0, 32'h21, 1, 0, 1'b1, '0, 0, 1'b0);
        run_access("byte-mem word store BE", 1'b1, 32'h60, 2, 0, 1'b1, 32'hA1B2C3D4, 0, 1'b0);
    endtask

    // R5, R9: byte and halfword on wide memory use a single cycle.
    task automatic t_wide_memory();
        run_access("32-mem byte load", 1'b0, 32'h23, 0, 2, 1'b0, '0, 0, 1'b0);
        run_access("16-mem half store", 1'b1, 32'h42, 1, 1, 1'b0, 32'h0000BEEF, 0, 1'b0);
        run_access("32-mem half store BE", 1'b1, 32'h72, 1, 2, 1'b1, 32'h00001234, 0, 1'b0);
    endtask

    // R3, R4, R7: accesses that cross memory word boundaries.
    task automatic t_misaligned();
        run_access("32-mem word split LE", 1'b0, 32'h31, 2, 2, 1'b0, '0, 0, 1'b0);
        run_access("16-mem word split BE store", 1'b1, 32'h53, 2, 1, 1'b1, 32'h11223344, 0, 1'b0);
        run_access("32-mem half split BE", 1'b0, 32'h87, 1, 2, 1'b1, '0, 0, 1'b0);
    endtask

    // R10: wait states stretch each cycle.
    task automatic t_wait_states();
        run_access("16-mem word wait3", 1'b0, 32'h91, 2, 1, 1'b0, '0, 3, 1'b0);
        run_access("byte-mem half store wait2", 1'b1, 32'hA5, 1, 0, 1'b0, 32'h0000CAFE, 2, 1'b0);
    endtask

    // R12: inputs changed mid-access are ignored.
    task automatic t_busy_ignore();
        run_access("R12 scrambled load", 1'b0, 32'hB2, 2, 0, 1'b1, '0, 1, 1'b1);
        run_access("R12 scrambled store", 1'b1, 32'hC3, 2, 1, 1'b0, 32'h5566AA77, 0, 1'b1);
    endtask

    // R2 and R13: code 3 clamps to full width; widths change between accesses.
    task automatic t_width_mix();
        run_access("R2 code3 word on code3 mem", 1'b0, 32'hD4, 3, 3, 1'b0, '0, 0, 1'b0);
        run_access("R2 code3 split", 1'b0, 32'hD6, 3, 3, 1'b1, '0, 0, 1'b0);
        run_access("R13 mix 8", 1'b0, 32'hE1, 2, 0, 1'b0, '0, 0, 1'b0);
        run_access("R13 mix 32", 1'b0, 32'hE1, 2, 2, 1'b0, '0, 0, 1'b0);
        run_access("R13 mix 16", 1'b0, 32'hE1, 2, 1, 1'b0, '0, 0, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem_img[i] = 8'(i) ^ 8'h5A;
        t_reset();
        t_narrow_memory();
        t_wide_memory();
        t_misaligned();
        t_wait_states();
        t_busy_ignore();
        t_width_mix();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog act=%0d exp=done", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule